// File: doc/BRIEF.md
# Sandcastle Level Timing Generator

This block decides, every internal clock cycle, which of three levels a combined blanking/clamp sandcastle line must show: base, blanking or clamp. It puts a video clamp pulse at a programmable offset after each line sync. It raises horizontal blanking ahead of the flyback centre and drops it at the flyback trailing edge. It also produces field blanking after each vertical reset. The analog level drivers sit outside the block and are driven from the 2-bit level code.

Field blanking also protects the picture tube. An unblanking window is opened inside every field-blanking interval, and the vertical output stage is expected to fill it with a guard pulse. The guard pulse reaches the block as a digital sense bit. Blanking is released at the end of the interval only if the guard was seen inside the window; if it was not, blanking stays on until a later field sees the guard again. Power-on, disable and the wait/stop operating modes also force blanking. A suppress control removes the clamp pulse in the non-scan modes.

Timing convention used below: a strobe input is sampled at a rising clock edge, and "cycle j" is the j-th clock period after that edge, with the period that directly follows the edge being cycle 0. K is the number of clocks per line (default 432). The mode input encodes 00 scan, 01 wait, 10 stop and 11 protect.

Top module: `sandcastle_gen`

## Requirements
- R1: A clamp pulse is exactly 21 consecutive cycles long, unless it is suppressed or cut short by a new line sync.
- R2: The clamp pulse covers cycles 35+2N to 55+2N after the edge that samples the line sync, where N is the 3-bit clamp shift. This gives a start between 35 and 49.
- R3: With the clamp suppress bit at 1 and the mode at wait (01), stop (10) or protect (11), no clamp code is produced. In scan mode (00), or with suppress at 0, the clamp pulse appears as usual.
- R4: Horizontal blanking starts in cycle K−(41−(432−K)) after the edge that samples the flyback-centre strobe; for K=432 this is cycle 391, which lies 41 clocks before the next centre. It stays on until the edge that samples the flyback trailing-edge strobe, after which it is off.
- R5: Field blanking starts in cycle 2 after the edge that samples the vertical reset.
- R6: Field blanking ends after cycle (S+1)·K+1, so it lasts S+1 lines, where S is the 6-bit start-scan value.
- R7: In cycles 48(S+1)+2 up to 96(S+1)+1 of a field, field blanking and any held blanking are lifted; this is the unblanking window.
- R8: If the guard-sense bit is 1 in at least one window cycle of a field, blanking is released when that field's blanking ends. If it is not, blanking is held on in every cycle outside the windows until a later field's end finds a guard. Guard pulses outside the window have no effect.
- R9: While the power-on flag is 1 or the enable is 0, blanking is on in every cycle, windows included.
- R10: In wait and stop modes, blanking is on in every cycle. Protect mode adds no blanking.
- R11: The level code is 00 base, 01 blanking, 10 clamp, and never 11. Clamp overrides blanking, and blanking overrides base.
- R12: During reset and right after it, the code is 01: no guard has been seen yet, and no clamp or horizontal blanking is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal line-locked clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | One-cycle strobe at the line sync leading edge |
| fb_centre_i | input | 1 | One-cycle strobe at the flyback pulse centre |
| fb_trail_i | input | 1 | One-cycle strobe at the flyback trailing-edge slicing crossing |
| vsync_i | input | 1 | One-cycle vertical reset strobe |
| clamp_shift_i | input | 3 | Clamp position step N |
| start_scan_i | input | 6 | Field-blanking length in lines minus one |
| guard_i | input | 1 | Digital guard-pulse sense |
| clamp_sup_i | input | 1 | Suppress the clamp pulse in the non-scan modes |
| por_i | input | 1 | Power-on flag, forces blanking |
| enable_i | input | 1 | Line/field start enable, 0 forces blanking |
| mode_i | input | 2 | Operating mode: 00 scan, 01 wait, 10 stop, 11 protect |
| level_o | output | 2 | Sandcastle level code |

## Verification
The clamp pulse and blanking can fall in the same cycle, and this overlap is where the priority rule is judged. The bench provokes it in two ways. It moves the flyback strobes so that the horizontal blanking interval spans the whole clamp position. It also lets clamp pulses run during field blanking, during the held no-guard state and during the wait mode with suppression off. In each of these cycles the expected code is computed independently as 10, and the cycles on either side of the pulse must fall back to 01.

// File: rtl/sc_pkg.sv
// Shared types for the sandcastle level generator.
// Assumes a 2-bit mode code and a 2-bit level code at the block edge.
package sc_pkg;
    typedef enum logic [1:0] {
        MODE_SCAN = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_STOP = 2'b10,
        MODE_PROT = 2'b11
    } sc_mode_e;

    typedef enum logic [1:0] {
        LVL_BASE  = 2'b00,
        LVL_BLANK = 2'b01,
        LVL_CLAMP = 2'b10
    } sc_level_e;
endpackage

// File: rtl/sc_clamp_gen.sv
// Clamp pulse generator: counts clocks from the sampled line sync and
// raises clamp_o for CLAMP_W clocks starting CLAMP_BASE + 2*shift.
// Assumes one-cycle sync strobes; the counter parks at all-ones between lines.
module sc_clamp_gen
    import sc_pkg::*;
#(
    parameter int SHIFT_W    = 3,
    parameter int CLAMP_BASE = 35,
    parameter int CLAMP_W    = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               sup_en_i,
    input  sc_mode_e           mode_i,
    output logic               clamp_o
);
    localparam int MAX_END = CLAMP_BASE + 2 * ((1 << SHIFT_W) - 1) + CLAMP_W;
    localparam int HCW     = $clog2(MAX_END + 1);

    logic [HCW-1:0] hcnt;
    logic [HCW-1:0] c_start;
    logic [HCW-1:0] c_stop;
    logic           suppressed;

    // Line-relative clock counter, saturating so no pulse repeats without sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '1;
        end else if (hsync_i) begin
            hcnt <= '0;
        end else if (hcnt != '1) begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Pulse window and mode-based suppression.
    always_comb begin
        c_start    = HCW'(CLAMP_BASE) + HCW'({shift_i, 1'b0});
        c_stop     = c_start + HCW'(CLAMP_W);
        suppressed = sup_en_i && (mode_i != MODE_SCAN);
        clamp_o    = (hcnt >= c_start) && (hcnt < c_stop) && !suppressed;
    end

    // Checker: run length of the clamp pulse.
    logic [HCW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (clamp_o) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_clamp_not_longer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_o |-> (run_len < HCW'(CLAMP_W)));

    assert_clamp_not_at_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_i |=> !clamp_o);
endmodule

// File: rtl/sc_hblank_gen.sv
// Horizontal blanking: predicts the next flyback centre from the last one
// and raises blanking LEAD clocks ahead of it; clears on the trailing strobe.
// Assumes a stable line length of LINE_CLKS clocks.
module sc_hblank_gen #(
    parameter int LINE_CLKS = 432
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_centre_i,
    input  logic fb_trail_i,
    output logic hb_o
);
    localparam int LEAD     = 41 - (432 - LINE_CLKS);
    localparam int HB_START = LINE_CLKS - LEAD;
    localparam int FCW      = $clog2(LINE_CLKS + 1);

    logic [FCW-1:0] fcnt;

    // Clocks since the sampled flyback centre, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '1;
        end else if (fb_centre_i) begin
            fcnt <= '0;
        end else if (fcnt != '1) begin
            fcnt <= fcnt + 1'b1;
        end
    end

    // Blanking flag: set at the predicted start, cleared by the trailing strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_o <= 1'b0;
        end else if (fb_trail_i) begin
            hb_o <= 1'b0;
        end else if (fcnt == FCW'(HB_START - 1)) begin
            hb_o <= 1'b1;
        end
    end

    assert_hblank_ends_on_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_trail_i |=> !hb_o);
endmodule

// File: rtl/sc_vblank_gen.sv
// Field blanking with guard check: blanks from VB_DELAY clocks after the
// vertical reset for (S+1) lines, opens an unblanking window inside, and
// keeps blanking held when no guard pulse filled that window.
// Assumes the start-scan value is stable during a field.
module sc_vblank_gen
    import sc_pkg::*;
#(
    parameter int LINE_CLKS = 432,
    parameter int SCAN_W    = 6,
    parameter int WIN_LO    = 48,
    parameter int WIN_HI    = 96,
    parameter int VB_DELAY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic [SCAN_W-1:0] scan_i,
    input  logic              guard_i,
    input  logic              por_i,
    input  logic              en_i,
    input  sc_mode_e          mode_i,
    output logic              vb_o
);
    localparam int VCW = $clog2((1 << SCAN_W) * LINE_CLKS + VB_DELAY + 1);

    logic [VCW-1:0] vcnt;
    logic           vactive;
    logic           guard_seen;
    logic           no_guard;
    logic [VCW-1:0] n_lines;
    logic [VCW-1:0] v_end;
    logic [VCW-1:0] w_lo;
    logic [VCW-1:0] w_hi;
    logic           in_window;
    logic           field_blank;
    logic           forced;
    logic           at_end;

    // Field boundaries derived from the start-scan value.
    always_comb begin
        n_lines     = VCW'(scan_i) + 1'b1;
        v_end       = n_lines * VCW'(LINE_CLKS) + VCW'(VB_DELAY);
        w_lo        = n_lines * VCW'(WIN_LO) + VCW'(VB_DELAY);
        w_hi        = n_lines * VCW'(WIN_HI) + VCW'(VB_DELAY);
        in_window   = vactive && (vcnt >= w_lo) && (vcnt < w_hi);
        field_blank = vactive && (vcnt >= VCW'(VB_DELAY)) && (vcnt < v_end);
        at_end      = vactive && (vcnt == v_end - 1'b1);
        forced      = por_i || !en_i || (mode_i == MODE_WAIT) || (mode_i == MODE_STOP);
        vb_o        = forced || ((field_blank || no_guard) && !in_window);
    end

    // Field counter: restarts on vertical reset, stops at the field end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt    <= '0;
            vactive <= 1'b0;
        end else if (vsync_i) begin
            vcnt    <= '0;
            vactive <= 1'b1;
        end else if (at_end) begin
            vactive <= 1'b0;
        end else if (vactive) begin
            vcnt <= vcnt + 1'b1;
        end
    end

    // Guard capture in the window and the hold decision at the field end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_seen <= 1'b0;
            no_guard   <= 1'b1;
        end else if (vsync_i) begin
            guard_seen <= 1'b0;
        end else if (at_end) begin
            no_guard <= !guard_seen;
        end else if (guard_i && in_window) begin
            guard_seen <= 1'b1;
        end
    end

    assert_vblank_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (por_i || !en_i) |-> vb_o);

    assert_vblank_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i ##1 !vsync_i ##1 !vsync_i |=> vb_o);

    assert_hold_outside_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (no_guard && !in_window) |-> vb_o);
endmodule

// File: rtl/sandcastle_gen.sv
// Sandcastle level generator top: combines clamp, horizontal blanking and
// field blanking into a 2-bit level code with clamp > blanking > base.
// Assumes all strobes are one clock wide and synchronous to clk.
module sandcastle_gen
    import sc_pkg::*;
#(
    parameter int LINE_CLKS  = 432,
    parameter int SHIFT_W    = 3,
    parameter int SCAN_W     = 6,
    parameter int CLAMP_BASE = 35,
    parameter int CLAMP_W    = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              fb_centre_i,
    input  logic              fb_trail_i,
    input  logic              vsync_i,
    input  logic [SHIFT_W-1:0] clamp_shift_i,
    input  logic [SCAN_W-1:0] start_scan_i,
    input  logic              guard_i,
    input  logic              clamp_sup_i,
    input  logic              por_i,
    input  logic              enable_i,
    input  logic [1:0]        mode_i,
    output logic [1:0]        level_o
);
    sc_mode_e mode;
    logic     clamp_w;
    logic     hb_w;
    logic     vb_w;

    assign mode = sc_mode_e'(mode_i);

    sc_clamp_gen #(
        .SHIFT_W    (SHIFT_W),
        .CLAMP_BASE (CLAMP_BASE),
        .CLAMP_W    (CLAMP_W)
    ) u_clamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_i  (hsync_i),
        .shift_i  (clamp_shift_i),
        .sup_en_i (clamp_sup_i),
        .mode_i   (mode),
        .clamp_o  (clamp_w)
    );

    sc_hblank_gen #(
        .LINE_CLKS (LINE_CLKS)
    ) u_hblank (
        .clk         (clk),
        .rst_n       (rst_n),
        .fb_centre_i (fb_centre_i),
        .fb_trail_i  (fb_trail_i),
        .hb_o        (hb_w)
    );

    sc_vblank_gen #(
        .LINE_CLKS (LINE_CLKS),
        .SCAN_W    (SCAN_W)
    ) u_vblank (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_i (vsync_i),
        .scan_i  (start_scan_i),
        .guard_i (guard_i),
        .por_i   (por_i),
        .en_i    (enable_i),
        .mode_i  (mode),
        .vb_o    (vb_w)
    );

    // Level priority: clamp over blanking over base.
    always_comb begin
        if (clamp_w) begin
            level_o = LVL_CLAMP;
        end else if (hb_w || vb_w) begin
            level_o = LVL_BLANK;
        end else begin
            level_o = LVL_BASE;
        end
    end

    assert_no_code_11_R11: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 2'b11);

    assert_wait_blanks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b01) && !clamp_w) |-> (level_o == LVL_BLANK));
endmodule

// File: tb/sim_sandcastle_gen.sv
// Scoreboard bench: the driver computes the expected level for each cycle
// from the requirements and queues it; a monitor pops and compares mid-cycle.
module sim_sandcastle_gen;
    localparam int K    = 432;
    localparam int HBS  = K - (41 - (432 - K));

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_i = 0, fb_centre_i = 0, fb_trail_i = 0, vsync_i = 0, guard_i = 0;
    logic [2:0] clamp_shift_i = 0;
    logic [5:0] start_scan_i = 1;
    logic       clamp_sup_i = 0, por_i = 0, enable_i = 0;
    logic [1:0] mode_i = 0;
    logic [1:0] level_o;

    always #5 clk = ~clk;

    sandcastle_gen u0 (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .fb_centre_i(fb_centre_i),
        .fb_trail_i(fb_trail_i), .vsync_i(vsync_i), .clamp_shift_i(clamp_shift_i),
        .start_scan_i(start_scan_i), .guard_i(guard_i), .clamp_sup_i(clamp_sup_i),
        .por_i(por_i), .enable_i(enable_i), .mode_i(mode_i), .level_o(level_o)
    );

    logic [1:0] q_lvl[$];
    string      q_tag[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench-side event history.
    int n = 0;
    bit h_valid = 0, f_valid = 0, v_open = 0, seen = 0, ng = 1, hb_b = 0;
    int e_h = 0, e_f = 0, e_v = 0;
    bit p_hs = 0, p_fc = 0, p_tr = 0, p_vs = 0, p_gd = 0;

    task automatic cyc(input bit hs, input bit fc, input bit tr, input bit vs, input bit gd);
        int vend, w0, w1, jv, jh, cst;
        bit craw, sup, cl, win, fb, frc, vb;
        logic [1:0] lv;
        string tg;
        vend = (int'(start_scan_i) + 1) * K + 2;
        w0   = (int'(start_scan_i) + 1) * 48 + 2;
        w1   = (int'(start_scan_i) + 1) * 96 + 2;
        // effects of the edge that started this cycle
        jv = n - 1 - e_v;
        if (p_gd && v_open && jv >= w0 && jv < w1) seen = 1;
        if (p_vs) begin
            v_open = 1; e_v = n; seen = 0;
        end else if (v_open && (n - e_v) == vend) begin
            v_open = 0; ng = !seen;
        end
        if (p_tr) hb_b = 0;
        else if (f_valid && (n - e_f) == HBS) hb_b = 1;
        if (p_fc) begin f_valid = 1; e_f = n; end
        if (p_hs) begin h_valid = 1; e_h = n; end
        // expected level in this cycle
        jh   = n - e_h;
        cst  = 35 + 2 * int'(clamp_shift_i);
        craw = h_valid && jh >= cst && jh < cst + 21;
        sup  = clamp_sup_i && (mode_i != 2'b00);
        cl   = craw && !sup;
        jv   = n - e_v;
        win  = v_open && jv >= w0 && jv < w1;
        fb   = v_open && jv >= 2 && jv < vend;
        frc  = por_i || !enable_i || mode_i == 2'b01 || mode_i == 2'b10;
        vb   = frc || ((fb || ng) && !win);
        lv   = cl ? 2'b10 : ((hb_b || vb) ? 2'b01 : 2'b00);
        if (n == 0)                      tg = "R12";
        else if (craw && sup)            tg = "R3";
        else if (cl && (hb_b || vb))     tg = "R11";
        else if (cl)                     tg = (jh == cst) ? "R2" : "R1";
        else if (por_i || !enable_i)     tg = "R9";
        else if (frc)                    tg = "R10";
        else if (win)                    tg = "R7";
        else if (fb)                     tg = (jv == 2) ? "R5" : "R6";
        else if (ng)                     tg = "R8";
        else if (hb_b)                   tg = "R4";
        else                             tg = "R11";
        q_lvl.push_back(lv);
        q_tag.push_back(tg);
        hsync_i = hs; fb_centre_i = fc; fb_trail_i = tr; vsync_i = vs; guard_i = gd;
        p_hs = hs; p_fc = fc; p_tr = tr; p_vs = vs; p_gd = gd;
        n++;
        @(posedge clk);
        #1;
    endtask

    task automatic line(input int fc_off, input int tr_off, input int vs_off, input bit gd);
        for (int i = 0; i < K; i++) begin
            cyc(i == 0, i == fc_off, i == tr_off, i == vs_off, gd);
        end
    endtask

    // Monitor: compare the queued expectation mid-cycle.
    always @(negedge clk) begin
        if (q_lvl.size() > 0) begin
            logic [1:0] ev;
            string et;
            ev = q_lvl.pop_front();
            et = q_tag.pop_front();
            n_chk++;
            if (level_o !== ev) begin
                n_fail++;
                $display("FAIL %s: level_o=%b expected %b (bench cycle %0d)", et, level_o, ev, n);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #1;
        // R12: reset state holds the blanking code
        for (int i = 0; i < 4; i++) begin
            q_lvl.push_back(2'b01);
            q_tag.push_back("R12");
            @(posedge clk);
            #1;
        end
        rst_n = 1; enable_i = 1; por_i = 0; mode_i = 2'b00; start_scan_i = 6'd1;
        // no field yet: held blanking, clamp on top (R11, R12)
        repeat (3) line(200, 230, -1, 0);
        // field with guard in window: release (R5, R6, R7, R8)
        line(200, 230, 10, 1);
        repeat (3) line(200, 230, -1, 0);
        // field with guard only outside window: held (R8)
        line(200, 230, 10, 0);
        line(200, 230, -1, 1);
        repeat (2) line(200, 230, -1, 0);
        // guard restored, clamp shift steps (R1, R2)
        clamp_shift_i = 3'd7;
        line(200, 230, 10, 1);
        clamp_shift_i = 3'd3;
        repeat (3) line(200, 230, -1, 0);
        // longer field N=5 (R6, R7)
        start_scan_i = 6'd5; clamp_shift_i = 3'd5;
        line(200, 230, 5, 1);
        repeat (7) line(200, 230, -1, 0);
        // modes and suppression (R3, R10)
        clamp_sup_i = 1; mode_i = 2'b01; repeat (2) line(200, 230, -1, 0);
        mode_i = 2'b10; line(200, 230, -1, 0);
        mode_i = 2'b11; line(200, 230, -1, 0);
        clamp_sup_i = 0; mode_i = 2'b01; line(200, 230, -1, 0);
        clamp_sup_i = 1; mode_i = 2'b00; line(200, 230, -1, 0);
        clamp_sup_i = 0;
        // power-on flag and disable force blanking even in the window (R9)
        start_scan_i = 6'd0;
        por_i = 1; line(200, 230, 3, 1);
        por_i = 0; line(200, 230, -1, 0);
        enable_i = 0; line(200, 230, 3, 1);
        enable_i = 1; line(200, 230, -1, 0);
        // clamp inside horizontal blanking (R4, R11)
        repeat (3) line(60, 100, -1, 0);
        // longest field N=63 (R6, R7, R8)
        start_scan_i = 6'd63; clamp_shift_i = 3'd0;
        line(200, 230, 7, 1);
        for (int l = 1; l < 20; l++) line(200, 230, -1, 1);
        for (int l = 20; l < 66; l++) line(200, 230, -1, 0);
        cyc(0, 0, 0, 0, 0);
        @(posedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule